// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits behind the bit-level receiver of an I2C slave and decides whether the address phase of a transfer is aimed at this device. The receiver hands it whole bytes with a strobe, and separate one-cycle strobes for a START (or repeated START) and for a STOP. The block compares the address byte, or bytes, against every enabled source. It then reports a match flag, a 7-bit match code and the transfer direction.

The first own address can be set to 7-bit or 10-bit mode. The second own address is 7-bit, and a 3-bit mask value makes the compare ignore its lowest bits. Four reserved addresses can also be accepted, each with its own enable: general call (0000000), SMBus alert response (0001100), SMBus device default (1100001) and SMBus host (0001000).

For a 10-bit transfer, the reported code is always the header prefix 11110 followed by the top two address bits. It is never the low byte of the address, even when that low byte looks like some other enabled 7-bit address. After a 10-bit write match, a read header sent after a repeated START selects transmit mode on the header byte alone.

Top module: `i2c_addr_matcher`

## Requirements
- R1: After reset, matchFlag, matchCode and dirTx are all 0.
- R2: In 7-bit mode with the first own address enabled, a first byte whose bits [7:1] equal oa1Addr[7:1] sets matchFlag=1, matchCode=byte[7:1] and dirTx=byte[0].
- R3: With oa2En=1, the second address matches when byte[7:1] and oa2Addr agree on every bit at or above position oa2Mask. Mask 0 compares all seven bits, and mask 7 accepts every address.
- R4: Each reserved address matches only when its own enable is set. The codes are: general call 0x00 (gcEn), alert 0x0C (alertEn), device default 0x61 (devDefEn) and host 0x08 (hostEn).
- R5: The outputs take their new value on the clock edge that samples the deciding byte strobe. A decision with no match drives matchFlag, matchCode and dirTx to 0.
- R6: In 10-bit mode, the header byte {11110, oa1Addr[9:8], 0} on its own leaves the outputs unchanged. A second byte equal to oa1Addr[7:0] then gives matchFlag=1, matchCode={11110, oa1Addr[9:8]} and dirTx=0. With oa1En=0 there is never a 10-bit match.
- R7: The 10-bit match has priority over every 7-bit source. The second byte is never compared as a 7-bit address. If the second byte does not equal oa1Addr[7:0], the outcome is the 7-bit compare of the header byte, with dirTx=0.
- R8: After a 10-bit write match and a repeated START, the read header {11110, oa1Addr[9:8], 1} gives matchFlag=1, the 10-bit code and dirTx=1. This holds for every oa1Addr, including values whose low byte has the shape of a read header. Without that earlier match in the same transfer, the read header is compared only as a 7-bit address.
- R9: A STOP strobe clears matchFlag, matchCode and dirTx on the next edge, and it cancels any earlier 10-bit match.
- R10: Byte strobes after the address phase, or before any START, leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startStb | input | 1 | One-cycle pulse on START or repeated START |
| stopStb | input | 1 | One-cycle pulse on STOP |
| byteStb | input | 1 | One-cycle pulse when byteData holds a received byte |
| byteData | input | 8 | Received byte, most significant bit first on the wire |
| oa1En | input | 1 | Enable for the first own address |
| oa1Is10 | input | 1 | First own address is 10-bit (1) or 7-bit (0) |
| oa1Addr | input | 10 | First own address; bits [7:1] are used in 7-bit mode |
| oa2En | input | 1 | Enable for the second own address |
| oa2Addr | input | 7 | Second own address |
| oa2Mask | input | 3 | Number of low bits of oa2Addr to ignore |
| gcEn | input | 1 | Accept general call |
| alertEn | input | 1 | Accept SMBus alert response address |
| devDefEn | input | 1 | Accept SMBus device default address |
| hostEn | input | 1 | Accept SMBus host address |
| matchFlag | output | 1 | The address phase selected this device |
| matchCode | output | 7 | Address code that matched |
| dirTx | output | 1 | 1 when the master reads (slave transmits) |

## Verification
The assertions check four rules on every cycle: a STOP clears the outputs, a 10-bit header byte leaves the outputs untouched, a fully masked second address always produces a match, and bytes outside the address phase hold the outputs steady. An armed read header must also always report transmit. Other behaviours only show up in the bench's scenarios. These are the exact code reported when a 10-bit address's low byte aliases an enabled 7-bit address, the fallback to the header's 7-bit result when the low byte differs, the read-header trap values, and the full sweep over mask values and address bytes.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned TEN_W  = 10;
  localparam int unsigned MASK_W = 3;
  localparam int unsigned RSV_N  = 4;
  localparam logic [4:0] HDR_PREFIX = 5'b11110;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;   // STOP seen
    logic openFrame;  // START / repeated START seen
    logic evalFirst;  // first address byte present
    logic evalSecond; // 10-bit low byte present
  } i2cm_ctl_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_LOW  = 2'd2,
    PH_DATA = 2'd3
  } i2cm_phase_t;
endpackage

// File: rtl/i2cm_addr_cmp.sv
module i2cm_addr_cmp
  import i2cm_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              oa1En,
  input  logic              oa1Is10,
  input  logic [TEN_W-1:0]  oa1Addr,
  input  logic              oa2En,
  input  logic [ADDR_W-1:0] oa2Addr,
  input  logic [MASK_W-1:0] oa2Mask,
  input  logic [RSV_N-1:0]  rsvEn,
  output logic              oa1Hit7,
  output logic              oa2Hit,
  output logic              rsvHit
);
  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};
  // Order: general call, alert, device default, host
  localparam logic [RSV_N-1:0][ADDR_W-1:0] RSV_CODE =
    {7'h08, 7'h61, 7'h0C, 7'h00};

  logic [ADDR_W-1:0] careBits;
  logic [RSV_N-1:0]  rsvEq;

  always_comb begin
    careBits = ALL_ONES << oa2Mask;
    oa1Hit7  = oa1En && !oa1Is10 && (addr == oa1Addr[ADDR_W:1]);
    oa2Hit   = oa2En && ((addr & careBits) == (oa2Addr & careBits));
  end

  for (genvar g = 0; g < RSV_N; g++) begin : g_rsv
    assign rsvEq[g] = rsvEn[g] && (addr == RSV_CODE[g]);
  end

  assign rsvHit = |rsvEq;
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startStb,
  input  logic      stopStb,
  input  logic      byteStb,
  input  logic      hdrWrHit,
  output i2cm_ctl_t ctl
);
  i2cm_phase_t phase, phaseNxt;

  always_comb begin
    ctl.clearAll   = stopStb;
    ctl.openFrame  = !stopStb && startStb;
    ctl.evalFirst  = !stopStb && !startStb && byteStb && (phase == PH_ADDR);
    ctl.evalSecond = !stopStb && !startStb && byteStb && (phase == PH_LOW);
  end

  always_comb begin
    phaseNxt = phase;
    if (stopStb)             phaseNxt = PH_IDLE;
    else if (startStb)       phaseNxt = PH_ADDR;
    else if (ctl.evalFirst)  phaseNxt = hdrWrHit ? PH_LOW : PH_DATA;
    else if (ctl.evalSecond) phaseNxt = PH_DATA;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNxt;
  end

  // R9: a STOP always returns the frame tracker to idle
  a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopStb |=> (phase == PH_IDLE));

  // R6: a 10-bit write header always waits for the low byte
  a_r6_header_waits_low: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.evalFirst && hdrWrHit) |=> (phase == PH_LOW));
endmodule

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  i2cm_ctl_t         ctl,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              oa1En,
  input  logic              oa1Is10,
  input  logic [TEN_W-1:0]  oa1Addr,
  input  logic              oa2En,
  input  logic [ADDR_W-1:0] oa2Addr,
  input  logic [MASK_W-1:0] oa2Mask,
  input  logic [RSV_N-1:0]  rsvEn,
  output logic              hdrWrHit,
  output logic              matchFlag,
  output logic [ADDR_W-1:0] matchCode,
  output logic              dirTx
);
  logic [ADDR_W-1:0] rxAddr;
  logic              rxRw;
  logic              hdrPrefix, hdrRdHit;
  logic              oa1Hit7, oa2Hit, rsvHit, any7;
  logic              tenArmed;
  logic              fbHit;
  logic [ADDR_W-1:0] pendCode;

  assign rxAddr = byteData[BYTE_W-1:1];
  assign rxRw   = byteData[0];

  i2cm_addr_cmp u_cmp (
    .addr    (rxAddr),
    .oa1En   (oa1En),
    .oa1Is10 (oa1Is10),
    .oa1Addr (oa1Addr),
    .oa2En   (oa2En),
    .oa2Addr (oa2Addr),
    .oa2Mask (oa2Mask),
    .rsvEn   (rsvEn),
    .oa1Hit7 (oa1Hit7),
    .oa2Hit  (oa2Hit),
    .rsvHit  (rsvHit)
  );

  always_comb begin
    hdrPrefix = oa1En && oa1Is10 &&
                (byteData[7:3] == HDR_PREFIX) &&
                (byteData[2:1] == oa1Addr[TEN_W-1:BYTE_W]);
    hdrWrHit  = hdrPrefix && !rxRw;
    hdrRdHit  = hdrPrefix && rxRw;
    any7      = oa1Hit7 || oa2Hit || rsvHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchFlag <= 1'b0;
      matchCode <= '0;
      dirTx     <= 1'b0;
      tenArmed  <= 1'b0;
      fbHit     <= 1'b0;
      pendCode  <= '0;
    end else if (ctl.clearAll) begin
      matchFlag <= 1'b0;
      matchCode <= '0;
      dirTx     <= 1'b0;
      tenArmed  <= 1'b0;
      fbHit     <= 1'b0;
    end else if (ctl.evalFirst) begin
      if (hdrRdHit && tenArmed) begin
        matchFlag <= 1'b1;
        matchCode <= rxAddr;
        dirTx     <= 1'b1;
      end else if (hdrWrHit) begin
        pendCode <= rxAddr;
        fbHit    <= any7;
        tenArmed <= 1'b0;
      end else begin
        matchFlag <= any7;
        matchCode <= any7 ? rxAddr : '0;
        dirTx     <= any7 && rxRw;
        tenArmed  <= 1'b0;
      end
    end else if (ctl.evalSecond) begin
      if (byteData == oa1Addr[BYTE_W-1:0]) begin
        matchFlag <= 1'b1;
        matchCode <= pendCode;
        dirTx     <= 1'b0;
        tenArmed  <= 1'b1;
      end else begin
        matchFlag <= fbHit;
        matchCode <= fbHit ? pendCode : '0;
        dirTx     <= 1'b0;
      end
    end
  end

  // R9: STOP clears the result
  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearAll |=> (!matchFlag && matchCode == '0 && !dirTx));

  // R5: no match means a zero code
  a_r5_code_zero_idle: assert property (@(posedge clk) disable iff (!rstN)
    !matchFlag |-> (matchCode == '0 && !dirTx));

  // R6: header byte alone does not move the outputs
  a_r6_header_silent: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.evalFirst && hdrWrHit) |=> ($stable(matchFlag) && $stable(matchCode) && $stable(dirTx)));

  // R8: an armed read header reports transmit with the header code
  a_r8_armed_read_tx: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.evalFirst && hdrRdHit && tenArmed) |=> (matchFlag && dirTx && matchCode[6:2] == HDR_PREFIX));

  // R3: a fully masked second address takes any plain 7-bit byte
  a_r3_full_mask: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.evalFirst && oa2En && oa2Mask == {MASK_W{1'b1}} && !hdrWrHit) |=> matchFlag);

  // R10: without an evaluation strobe the result holds
  a_r10_hold_outside_addr: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.clearAll || ctl.evalFirst || ctl.evalSecond) |=> ($stable(matchFlag) && $stable(matchCode) && $stable(dirTx)));
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2cm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startStb,
  input  logic        stopStb,
  input  logic        byteStb,
  input  logic [7:0]  byteData,
  input  logic        oa1En,
  input  logic        oa1Is10,
  input  logic [9:0]  oa1Addr,
  input  logic        oa2En,
  input  logic [6:0]  oa2Addr,
  input  logic [2:0]  oa2Mask,
  input  logic        gcEn,
  input  logic        alertEn,
  input  logic        devDefEn,
  input  logic        hostEn,
  output logic        matchFlag,
  output logic [6:0]  matchCode,
  output logic        dirTx
);
  i2cm_ctl_t        ctl;
  logic             hdrWrHit;
  logic [RSV_N-1:0] rsvEn;

  assign rsvEn = {hostEn, devDefEn, alertEn, gcEn};

  i2cm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startStb (startStb),
    .stopStb  (stopStb),
    .byteStb  (byteStb),
    .hdrWrHit (hdrWrHit),
    .ctl      (ctl)
  );

  i2cm_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .byteData  (byteData),
    .oa1En     (oa1En),
    .oa1Is10   (oa1Is10),
    .oa1Addr   (oa1Addr),
    .oa2En     (oa2En),
    .oa2Addr   (oa2Addr),
    .oa2Mask   (oa2Mask),
    .rsvEn     (rsvEn),
    .hdrWrHit  (hdrWrHit),
    .matchFlag (matchFlag),
    .matchCode (matchCode),
    .dirTx     (dirTx)
  );
endmodule

// File: tb/i2c_addr_matcher_tb.sv
`timescale 1ns/1ps
module i2c_addr_matcher_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startStb = 1'b0, stopStb = 1'b0, byteStb = 1'b0;
  logic [7:0] byteData = '0;
  logic       oa1En = 1'b0, oa1Is10 = 1'b0;
  logic [9:0] oa1Addr = '0;
  logic       oa2En = 1'b0;
  logic [6:0] oa2Addr = '0;
  logic [2:0] oa2Mask = '0;
  logic       gcEn = 1'b0, alertEn = 1'b0, devDefEn = 1'b0, hostEn = 1'b0;
  logic       matchFlag;
  logic [6:0] matchCode;
  logic       dirTx;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  i2c_addr_matcher u_dut (
    .clk(clk), .rstN(rstN), .startStb(startStb), .stopStb(stopStb),
    .byteStb(byteStb), .byteData(byteData), .oa1En(oa1En), .oa1Is10(oa1Is10),
    .oa1Addr(oa1Addr), .oa2En(oa2En), .oa2Addr(oa2Addr), .oa2Mask(oa2Mask),
    .gcEn(gcEn), .alertEn(alertEn), .devDefEn(devDefEn), .hostEn(hostEn),
    .matchFlag(matchFlag), .matchCode(matchCode), .dirTx(dirTx)
  );

  task automatic check(string tag, logic expFlag, logic [6:0] expCode, logic expDir);
    total++;
    if (matchFlag !== expFlag || matchCode !== expCode || dirTx !== expDir) begin
      bad++;
      $display("FAIL %s: got flag=%0b code=%02h dir=%0b, want flag=%0b code=%02h dir=%0b",
               tag, matchFlag, matchCode, dirTx, expFlag, expCode, expDir);
    end
  endtask

  task automatic doStart();
    @(negedge clk); startStb = 1'b1;
    @(negedge clk); startStb = 1'b0;
  endtask

  task automatic doStop();
    @(negedge clk); stopStb = 1'b1;
    @(negedge clk); stopStb = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] b);
    @(negedge clk); byteData = b; byteStb = 1'b1;
    @(negedge clk); byteStb = 1'b0;
  endtask

  // Expected 7-bit result from the requirements (R2, R3, R4)
  function automatic bit hit7(int a, int m);
    bit h;
    h = 1'b0;
    if (oa1En && !oa1Is10 && a == int'(oa1Addr[7:1])) h = 1'b1;
    if (oa2En && (((a ^ int'(oa2Addr)) >> m) == 0))   h = 1'b1;
    if (gcEn && a == 0)        h = 1'b1;
    if (alertEn && a == 12)    h = 1'b1;
    if (devDefEn && a == 97)   h = 1'b1;
    if (hostEn && a == 8)      h = 1'b1;
    return h;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 7'h00, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", 1'b0, 7'h00, 1'b0);

    // Sweep R2/R3/R4/R5/R9/R10 over mask, address and direction
    oa1En = 1'b1; oa1Is10 = 1'b0; oa1Addr = 10'h054;
    oa2En = 1'b1; oa2Addr = 7'h55;
    gcEn = 1'b1; alertEn = 1'b1; devDefEn = 1'b0; hostEn = 1'b1;
    for (int m = 0; m < 8; m++) begin
      oa2Mask = 3'(m);
      for (int a = 0; a < 128; a++) begin
        for (int rw = 0; rw < 2; rw++) begin
          bit h;
          h = hit7(a, m);
          doStart();
          sendByte(8'((a << 1) | rw));
          check("R2 R3 R4 R5 sweep", h, h ? 7'(a) : 7'h00, h && (rw == 1));
          sendByte(8'(~((a << 1) | rw)));
          check("R10 data byte", h, h ? 7'(a) : 7'h00, h && (rw == 1));
          doStop();
          check("R9 stop", 1'b0, 7'h00, 1'b0);
        end
      end
    end

    // R10: byte before any START is ignored
    oa2Mask = 3'd0;
    sendByte(8'h54);
    check("R10 idle byte", 1'b0, 7'h00, 1'b0);

    // R4: each reserved address against each enable pattern
    oa1En = 1'b0; oa2En = 1'b0;
    for (int e = 0; e < 16; e++) begin
      {hostEn, devDefEn, alertEn, gcEn} = 4'(e);
      for (int k = 0; k < 4; k++) begin
        int code;
        bit h;
        code = (k == 0) ? 0 : (k == 1) ? 12 : (k == 2) ? 97 : 8;
        h = ((e >> k) & 1) == 1;
        doStart();
        sendByte(8'(code << 1));
        check("R4 reserved enable", h, h ? 7'(code) : 7'h00, 1'b0);
        doStop();
      end
    end
    {hostEn, devDefEn, alertEn, gcEn} = 4'b0000;

    // R7: low byte aliases an enabled 7-bit address and device default
    oa1En = 1'b1; oa1Is10 = 1'b1; oa1Addr = 10'h2C3;
    oa2En = 1'b1; oa2Addr = 7'h61; oa2Mask = 3'd0; devDefEn = 1'b1;
    doStart();
    sendByte(8'hF4);
    check("R6 header silent", 1'b0, 7'h00, 1'b0);
    sendByte(8'hC3);
    check("R7 10-bit wins over alias", 1'b1, 7'h7A, 1'b0);
    doStart();
    sendByte(8'hF5);
    check("R8 read header after rSTART", 1'b1, 7'h7A, 1'b1);
    sendByte(8'h61);
    check("R10 data after read", 1'b1, 7'h7A, 1'b1);
    doStop();
    check("R9 stop after 10-bit", 1'b0, 7'h00, 1'b0);
    doStart();
    sendByte(8'hF5);
    check("R8 read header unarmed", 1'b0, 7'h00, 1'b0);
    doStop();
    devDefEn = 1'b0;

    // R7: mismatched low byte falls back to the header's 7-bit result
    oa2Addr = 7'h7A;
    doStart();
    sendByte(8'hF4);
    sendByte(8'h00);
    check("R7 fallback to OA2", 1'b1, 7'h7A, 1'b0);
    doStop();
    oa2En = 1'b0;
    doStart();
    sendByte(8'hF4);
    sendByte(8'h00);
    check("R7 low mismatch no fallback", 1'b0, 7'h00, 1'b0);
    doStop();

    // R8: low bytes shaped like a read header
    for (int t = 0; t < 4; t++) begin
      logic [9:0] v;
      v = {2'(t), 5'b11110, 2'(t), 1'b1};
      oa1Addr = v;
      doStart();
      sendByte({5'b11110, v[9:8], 1'b0});
      sendByte(v[7:0]);
      check("R6 trap write", 1'b1, {5'b11110, v[9:8]}, 1'b0);
      doStart();
      sendByte({5'b11110, v[9:8], 1'b1});
      check("R8 trap read dir", 1'b1, {5'b11110, v[9:8]}, 1'b1);
      doStop();
    end

    // R6: 10-bit address disabled
    oa1En = 1'b0; oa1Addr = 10'h2C3;
    doStart();
    sendByte(8'hF4);
    sendByte(8'hC3);
    check("R6 disabled", 1'b0, 7'h00, 1'b0);
    doStop();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule